// File: doc/BRIEF.md
# Cache Replacement Victim Selector

This block decides which way of a set-associative cache set gets evicted when a conflict miss needs room. It keeps only replacement metadata, never tags or data. The surrounding cache controller reports every hit and every fill on an update strobe carrying the set, the way and a fill qualifier. When it needs a victim, it raises a request strobe with the set index, and the chosen way appears on the output one clock later.

Three replacement rules are available:

- **Least recently used.** Each set owns a generation counter. Every hit or fill writes the counter into a per-way stamp, and the victim is the way with the smallest stamp.
- **First in, first out.** Each set owns a small circular queue of way indices. Only fills enter the queue, and a victim request removes the oldest entry.
- **Pseudo-random.** The victim is taken from the low bits of a free-running linear feedback shift register.

The rule is either fixed by a parameter or, when `RUNTIME_POLICY` is set, taken from a two-bit configuration input. Only the state of the active rule records events.

Top module: `victim_select`

## Requirements
- R1: After reset every generation counter and every stamp is zero, every queue is empty, and `vic_valid` and `vic_way` are 0. A least-recently-used request to any set that has seen no update then returns way 0.
- R2: In least-recently-used mode, a hit (`upd_fill`=0) and a fill (`upd_fill`=1) have the same effect. The set's current generation value is written into the accessed way's stamp, and then that set's counter advances by one.
- R3: The least-recently-used victim is the way with the smallest stamp. When stamps are equal, the lowest-numbered way wins.
- R4: A generation counter stops at its all-ones value (2^GEN_W - 1). Later updates stamp that value, so ways stamped after saturation tie, and the lowest-numbered of them is chosen.
- R5: In first-in-first-out mode, a fill appends the filled way to the set's queue. A hit leaves the queue unchanged.
- R6: In first-in-first-out mode, a victim request returns the oldest queued way of the set and removes it from the queue.
- R7: A first-in-first-out request to a set with an empty queue, and no fill to that set in the same cycle, returns way 0 and changes nothing.
- R8: A fill to a set whose queue already holds NUM_WAYS entries is discarded. The exception is a cycle in which a request also pops that same set: then the oldest entry leaves and the filled way becomes the newest entry.
- R9: In random mode the victim is the low log2(NUM_WAYS) bits of a shift register that steps every clock and never holds zero. Every way is reachable.
- R10: `vic_valid` is high exactly in the cycle after a request. `vic_way` changes only in the cycle after a request and otherwise holds its value.
- R11: An update to the requested set in the same cycle as the request is applied before the victim is chosen. In least-recently-used mode the new stamp takes part in the choice. In first-in-first-out mode, a fill into an empty queue is returned at once.
- R12: `pol_cfg` selects the rule: 0 is least recently used, 1 is first in first out, 2 is random, and 3 behaves as 0. Updates made while one rule is active leave the state of the other rule untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pol_cfg | input | 2 | Replacement rule select when runtime selection is enabled |
| upd_valid | input | 1 | Hit or fill event strobe |
| upd_fill | input | 1 | 1 = fill, 0 = hit |
| upd_set | input | $clog2(NUM_SETS) | Set of the event |
| upd_way | input | $clog2(NUM_WAYS) | Way of the event |
| vic_req | input | 1 | Victim request strobe |
| vic_set | input | $clog2(NUM_SETS) | Set to pick a victim in |
| vic_way | output | $clog2(NUM_WAYS) | Chosen victim way, registered |
| vic_valid | output | 1 | High in the cycle after a request |

## Verification
The bench builds the block with four sets, four ways, a five-bit generation counter and runtime rule selection. With these values the counters saturate after only 31 updates to a set, so the tie-breaking of R4 comes up constantly under random traffic. With only four sets, full queues, empty pops and same-set collisions between update and request also occur often. A model of stamps, counters and queues inside the bench predicts every victim for the two deterministic rules. The random rule is checked for coverage of all ways.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
   typedef enum logic [1:0] {
      POL_LRU  = 2'd0,
      POL_FIFO = 2'd1,
      POL_RAND = 2'd2,
      POL_RSVD = 2'd3
   } vsel_pol_e;
endpackage

// File: rtl/vsel_lru_track.sv
module vsel_lru_track #(
   parameter int NUM_SETS = 32,
   parameter int NUM_WAYS = 8,
   parameter int GEN_W    = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        upd_en,
   input  logic [$clog2(NUM_SETS)-1:0] upd_set,
   input  logic [$clog2(NUM_WAYS)-1:0] upd_way,
   input  logic [$clog2(NUM_SETS)-1:0] vic_set,
   output logic [$clog2(NUM_WAYS)-1:0] vic_way
);
   localparam int WAY_W = $clog2(NUM_WAYS);
   localparam logic [GEN_W-1:0] GEN_MAX = '1;

   logic [GEN_W-1:0] gen_q [NUM_SETS];
   logic [GEN_W-1:0] pri_q [NUM_SETS][NUM_WAYS];
   logic [GEN_W-1:0] eff_pri [NUM_WAYS];
   logic [GEN_W-1:0] min_pri;
   logic             fwd;

   // stamps seen by the selector, with a same-set update forwarded in
   always_comb begin
      fwd = upd_en && (upd_set == vic_set);
      for (int w = 0; w < NUM_WAYS; w++) begin
         if (fwd && (upd_way == WAY_W'(w))) eff_pri[w] = gen_q[vic_set];
         else                               eff_pri[w] = pri_q[vic_set][w];
      end
   end

   // strict less-than scan from way 0: ties resolve to the lowest way
   always_comb begin
      min_pri = eff_pri[0];
      vic_way = '0;
      for (int w = 1; w < NUM_WAYS; w++) begin
         if (eff_pri[w] < min_pri) begin
            min_pri = eff_pri[w];
            vic_way = WAY_W'(w);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SETS; s++) begin
            gen_q[s] <= '0;
            for (int w = 0; w < NUM_WAYS; w++) pri_q[s][w] <= '0;
         end
      end else if (upd_en) begin
         pri_q[upd_set][upd_way] <= gen_q[upd_set];
         if (gen_q[upd_set] != GEN_MAX) gen_q[upd_set] <= gen_q[upd_set] + 1'b1;
      end
   end

   AST_GEN_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> gen_q[$past(upd_set)] >= $past(gen_q[upd_set])) else $error("gen counter decreased"); // R4
   AST_LRU_VICTIM_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      eff_pri[vic_way] <= eff_pri[0]) else $error("victim stamp above way 0 stamp"); // R3
endmodule

// File: rtl/vsel_fifo_track.sv
module vsel_fifo_track #(
   parameter int NUM_SETS = 32,
   parameter int NUM_WAYS = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        push_en,
   input  logic [$clog2(NUM_SETS)-1:0] upd_set,
   input  logic [$clog2(NUM_WAYS)-1:0] upd_way,
   input  logic                        pop_en,
   input  logic [$clog2(NUM_SETS)-1:0] vic_set,
   output logic [$clog2(NUM_WAYS)-1:0] vic_way,
   output logic                        vic_empty
);
   localparam int SET_W = $clog2(NUM_SETS);
   localparam int WAY_W = $clog2(NUM_WAYS);
   localparam int CNT_W = WAY_W + 1;

   logic [WAY_W-1:0] ent_q  [NUM_SETS][NUM_WAYS];
   logic [WAY_W-1:0] head_q [NUM_SETS];
   logic [WAY_W-1:0] tail_q [NUM_SETS];
   logic [CNT_W-1:0] cnt_q  [NUM_SETS];
   logic [NUM_SETS-1:0] inc_s, dec_s;
   logic [CNT_W-1:0] pop_cnt, push_cnt;
   logic same, pop_do, push_do;

   always_comb begin
      pop_cnt   = cnt_q[vic_set];
      push_cnt  = cnt_q[upd_set];
      same      = push_en && (upd_set == vic_set);
      vic_empty = (pop_cnt == '0);
      pop_do    = pop_en && (!vic_empty || same);
      push_do   = push_en && ((push_cnt < CNT_W'(NUM_WAYS)) || (pop_do && same));
      if (!vic_empty) vic_way = ent_q[vic_set][head_q[vic_set]];
      else if (same)  vic_way = upd_way;
      else            vic_way = '0;
      for (int s = 0; s < NUM_SETS; s++) begin
         inc_s[s] = push_do && (upd_set == SET_W'(s));
         dec_s[s] = pop_do  && (vic_set == SET_W'(s));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SETS; s++) begin
            head_q[s] <= '0;
            tail_q[s] <= '0;
            cnt_q[s]  <= '0;
            for (int w = 0; w < NUM_WAYS; w++) ent_q[s][w] <= '0;
         end
      end else begin
         if (push_do) begin
            ent_q[upd_set][tail_q[upd_set]] <= upd_way;
            tail_q[upd_set] <= tail_q[upd_set] + 1'b1;
         end
         if (pop_do) head_q[vic_set] <= head_q[vic_set] + 1'b1;
         for (int s = 0; s < NUM_SETS; s++)
            cnt_q[s] <= cnt_q[s] + CNT_W'(inc_s[s]) - CNT_W'(dec_s[s]);
      end
   end

   AST_FIFO_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[vic_set] <= CNT_W'(NUM_WAYS)) else $error("queue over depth"); // R8
   AST_FIFO_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (push_en && !pop_en && push_cnt == CNT_W'(NUM_WAYS)) |=> cnt_q[$past(upd_set)] == CNT_W'(NUM_WAYS))
      else $error("full queue changed"); // R8
endmodule

// File: rtl/vsel_lfsr.sv
module vsel_lfsr #(
   parameter int                LFSR_W = 16,
   parameter logic [LFSR_W-1:0] TAPS   = 16'hB400,
   parameter logic [LFSR_W-1:0] SEED   = 16'hACE1,
   parameter int                OUT_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [OUT_W-1:0] rnd
);
   logic [LFSR_W-1:0] state_q;

   initial begin
      assert (OUT_W <= LFSR_W) else $error("LFSR narrower than output");
      assert (SEED != '0) else $error("LFSR seed must be nonzero");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          state_q <= SEED;
      else if (state_q[0]) state_q <= (state_q >> 1) ^ TAPS;
      else                 state_q <= state_q >> 1;
   end

   assign rnd = state_q[OUT_W-1:0];

   AST_LFSR_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != '0) else $error("LFSR locked at zero"); // R9
endmodule

// File: rtl/victim_select.sv
module victim_select #(
   parameter int NUM_SETS       = 32,
   parameter int NUM_WAYS       = 8,
   parameter int GEN_W          = 16,
   parameter int LFSR_W         = 16,
   parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
   parameter bit RUNTIME_POLICY = 1'b1,
   parameter int FIXED_POLICY   = 0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [1:0]                  pol_cfg,
   input  logic                        upd_valid,
   input  logic                        upd_fill,
   input  logic [$clog2(NUM_SETS)-1:0] upd_set,
   input  logic [$clog2(NUM_WAYS)-1:0] upd_way,
   input  logic                        vic_req,
   input  logic [$clog2(NUM_SETS)-1:0] vic_set,
   output logic [$clog2(NUM_WAYS)-1:0] vic_way,
   output logic                        vic_valid
);
   import vsel_pkg::*;
   localparam int  WAY_W    = $clog2(NUM_WAYS);
   localparam bit  HAS_LRU  = RUNTIME_POLICY || (FIXED_POLICY == 0) || (FIXED_POLICY == 3);
   localparam bit  HAS_FIFO = RUNTIME_POLICY || (FIXED_POLICY == 1);
   localparam bit  HAS_RAND = RUNTIME_POLICY || (FIXED_POLICY == 2);

   initial begin
      assert (NUM_SETS >= 2 && (NUM_SETS & (NUM_SETS - 1)) == 0) else $error("NUM_SETS must be a power of two >= 2");
      assert (NUM_WAYS >= 2 && (NUM_WAYS & (NUM_WAYS - 1)) == 0) else $error("NUM_WAYS must be a power of two >= 2");
      assert (GEN_W >= 1) else $error("GEN_W must be positive");
      assert (FIXED_POLICY >= 0 && FIXED_POLICY <= 3) else $error("FIXED_POLICY out of range");
   end

   vsel_pol_e pol_raw, pol_act;
   logic lru_sel, fifo_sel;
   logic [WAY_W-1:0] lru_way, fifo_way, rnd_way, pick;
   logic fifo_empty;

   always_comb begin
      pol_raw  = RUNTIME_POLICY ? vsel_pol_e'(pol_cfg) : vsel_pol_e'(2'(FIXED_POLICY));
      pol_act  = (pol_raw == POL_RSVD) ? POL_LRU : pol_raw;
      lru_sel  = (pol_act == POL_LRU);
      fifo_sel = (pol_act == POL_FIFO);
   end

   if (HAS_LRU) begin : g_lru
      vsel_lru_track #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .GEN_W(GEN_W)) u_lru (
         .clk(clk), .rst_n(rst_n), .upd_en(upd_valid && lru_sel),
         .upd_set(upd_set), .upd_way(upd_way), .vic_set(vic_set), .vic_way(lru_way));
   end else begin : g_no_lru
      assign lru_way = '0;
   end

   if (HAS_FIFO) begin : g_fifo
      vsel_fifo_track #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_fifo (
         .clk(clk), .rst_n(rst_n), .push_en(upd_valid && upd_fill && fifo_sel),
         .upd_set(upd_set), .upd_way(upd_way), .pop_en(vic_req && fifo_sel),
         .vic_set(vic_set), .vic_way(fifo_way), .vic_empty(fifo_empty));
   end else begin : g_no_fifo
      assign fifo_way   = '0;
      assign fifo_empty = 1'b1;
   end

   if (HAS_RAND) begin : g_rand
      vsel_lfsr #(.LFSR_W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED), .OUT_W(WAY_W)) u_lfsr (
         .clk(clk), .rst_n(rst_n), .rnd(rnd_way));
   end else begin : g_no_rand
      assign rnd_way = '0;
   end

   always_comb begin
      case (pol_act)
         POL_FIFO: pick = fifo_way;
         POL_RAND: pick = rnd_way;
         default:  pick = lru_way;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vic_way   <= '0;
         vic_valid <= 1'b0;
      end else begin
         vic_valid <= vic_req;
         if (vic_req) vic_way <= pick;
      end
   end

   AST_WAY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !vic_req |=> $stable(vic_way)) else $error("victim changed without request"); // R10
   AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      vic_req |=> vic_valid) else $error("missing valid"); // R10
   AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (vic_req && fifo_sel && fifo_empty && !(upd_valid && upd_fill && upd_set == vic_set))
      |=> vic_way == '0) else $error("empty queue pop not way 0"); // R7
endmodule

// File: tb/sim_victim_select.sv
module sim_victim_select;
   localparam int NS = 4, NW = 4, GW = 5;
   localparam int GMAX = (1 << GW) - 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [1:0] pol_cfg = 2'd0;
   logic upd_valid = 1'b0, upd_fill = 1'b0, vic_req = 1'b0;
   logic [1:0] upd_set = '0, upd_way = '0, vic_set = '0;
   logic [1:0] vic_way;
   logic vic_valid;

   int checks = 0, fails = 0, last_way = 0, seen = 0;
   int m_gen [NS];
   int m_pri [NS][NW];
   int m_q [NS][NW];
   int m_h [NS], m_t [NS], m_c [NS];

   always #2 clk = ~clk;

   victim_select #(.NUM_SETS(NS), .NUM_WAYS(NW), .GEN_W(GW)) u0 (
      .clk(clk), .rst_n(rst_n), .pol_cfg(pol_cfg), .upd_valid(upd_valid), .upd_fill(upd_fill),
      .upd_set(upd_set), .upd_way(upd_way), .vic_req(vic_req), .vic_set(vic_set),
      .vic_way(vic_way), .vic_valid(vic_valid));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int lru_min(input int s);
      int b = 0;
      for (int w = 1; w < NW; w++) if (m_pri[s][w] < m_pri[s][b]) b = w;
      return b;
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      upd_valid = 1'b0; vic_req = 1'b0;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      for (int s = 0; s < NS; s++) begin
         m_gen[s] = 0; m_h[s] = 0; m_t[s] = 0; m_c[s] = 0;
         for (int w = 0; w < NW; w++) begin m_pri[s][w] = 0; m_q[s][w] = 0; end
      end
      last_way = 0;
   endtask

   // one cycle: drive at negedge, predict, observe the registered result one clock later
   task automatic step(input string tag, input bit uv, input bit uf, input int us, input int uw,
                       input bit vr, input int vs);
      int p, exp_w;
      bit push, pop, same, popdo, pushdo;
      p = (pol_cfg == 2'd3) ? 0 : int'(pol_cfg);
      upd_valid = uv; upd_fill = uf; upd_set = 2'(us); upd_way = 2'(uw);
      vic_req = vr; vic_set = 2'(vs);
      exp_w = -1;
      if (p == 0) begin
         if (uv) begin
            m_pri[us][uw] = m_gen[us];
            if (m_gen[us] < GMAX) m_gen[us]++;
         end
         if (vr) exp_w = lru_min(vs);
      end else if (p == 1) begin
         push = uv && uf; pop = vr; same = push && (us == vs);
         popdo = pop && (m_c[vs] > 0 || same);
         if (vr) exp_w = (m_c[vs] > 0) ? m_q[vs][m_h[vs]] : (same ? uw : 0);
         pushdo = push && (m_c[us] < NW || (popdo && same));
         if (pushdo) begin
            m_q[us][m_t[us]] = uw; m_t[us] = (m_t[us] + 1) % NW; m_c[us]++;
         end
         if (popdo) begin
            m_h[vs] = (m_h[vs] + 1) % NW; m_c[vs]--;
         end
      end
      @(negedge clk);
      upd_valid = 1'b0; vic_req = 1'b0;
      if (vr) begin
         chk(vic_valid === 1'b1, "R10 valid", int'(vic_valid), 1);
         if (exp_w >= 0) chk(vic_way === 2'(exp_w), tag, int'(vic_way), exp_w);
         else seen |= (1 << vic_way);
         last_way = int'(vic_way);
      end else begin
         chk(vic_valid === 1'b0, "R10 idle valid", int'(vic_valid), 0);
         chk(int'(vic_way) == last_way, "R10 hold", int'(vic_way), last_way);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd7411));
      do_reset();
      chk(vic_valid === 1'b0, "R1 reset valid", int'(vic_valid), 0);
      chk(vic_way === 2'd0, "R1 reset way", int'(vic_way), 0);

      // least recently used, directed
      pol_cfg = 2'd0;
      step("R1", 0, 0, 0, 0, 1, 0);
      step("R2", 1, 0, 1, 2, 0, 0);
      step("R3 tie", 0, 0, 0, 0, 1, 1);
      step("R2", 1, 1, 1, 0, 0, 0);
      step("R2", 1, 1, 1, 1, 0, 0);
      step("R2", 1, 1, 1, 3, 0, 0);
      step("R3 min", 0, 0, 0, 0, 1, 1);
      step("R2 hit", 1, 0, 1, 2, 0, 0);
      step("R3 min", 0, 0, 0, 0, 1, 1);
      step("R11 lru", 1, 0, 1, 0, 1, 1);
      // saturation
      for (int i = 0; i < 40; i++) step("R4", 1, i[0], 3, i % NW, 0, 0);
      step("R4 sat", 0, 0, 0, 0, 1, 3);
      step("R4 sat", 1, 0, 3, 0, 1, 3);

      // first in first out, directed
      do_reset(); pol_cfg = 2'd1;
      step("R7 empty", 0, 0, 0, 0, 1, 2);
      step("R5", 1, 1, 2, 3, 0, 0);
      step("R5", 1, 1, 2, 1, 0, 0);
      step("R5 hit", 1, 0, 2, 0, 0, 0);
      step("R6", 0, 0, 0, 0, 1, 2);
      step("R6", 0, 0, 0, 0, 1, 2);
      step("R7 empty", 0, 0, 0, 0, 1, 2);
      for (int w = 1; w <= NW; w++) step("R8 fill", 1, 1, 0, w % NW, 0, 0);
      step("R8 drop", 1, 1, 0, 2, 0, 0);
      step("R8 swap", 1, 1, 0, 3, 1, 0);
      for (int i = 0; i < NW; i++) step("R8 drain", 0, 0, 0, 0, 1, 0);
      step("R7 empty", 0, 0, 0, 0, 1, 0);
      step("R11 fifo", 1, 1, 1, 3, 1, 1);
      step("R7 after", 0, 0, 0, 0, 1, 1);

      // rule isolation and encoding 3
      pol_cfg = 2'd0;
      step("R12", 1, 1, 2, 0, 0, 0);
      step("R12", 1, 1, 2, 1, 0, 0);
      pol_cfg = 2'd1;
      step("R12", 1, 0, 2, 2, 0, 0);
      pol_cfg = 2'd2;
      step("R12", 1, 1, 3, 2, 0, 0);
      pol_cfg = 2'd1;
      step("R12 fifo untouched", 0, 0, 0, 0, 1, 3);
      pol_cfg = 2'd3;
      step("R12 lru untouched", 0, 0, 0, 0, 1, 2);
      step("R12 code3", 1, 0, 2, 2, 1, 2);

      // random rule
      pol_cfg = 2'd2; seen = 0;
      for (int i = 0; i < 64; i++) step("R9", 0, 0, 0, 0, 1, i % NS);
      chk(seen == 4'hF, "R9 coverage", seen, 15);

      // mixed constrained random traffic
      do_reset(); pol_cfg = 2'd0;
      for (int i = 0; i < 3000; i++) begin
         string tg;
         if ($urandom_range(0, 149) == 0) pol_cfg = 2'($urandom_range(0, 3));
         tg = (pol_cfg == 2'd1) ? "R6 rand" : (pol_cfg == 2'd2) ? "R9 rand" : "R3 rand";
         step(tg, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), $urandom_range(0, NS - 1),
              $urandom_range(0, NW - 1), 1'($urandom_range(0, 1)), $urandom_range(0, NS - 1));
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule